// File: doc/BRIEF.md
# Burst Line-Fill Memory Controller

This block sits between the cache-fill port of a processor and a synchronous static RAM. It moves one four-word cache line per request, either as a fill from memory or as a write-out to memory. The requester gives a single start word address and two control bits. The block produces the other three word addresses with an internal counter. It can step through the line in wrap-around order, starting at the requested word, or in linear order, starting at the first word of the line.

The memory is accessed synchronously through the block's own output registers. The first word costs two clocks and each later word costs one, so a whole line takes five clocks where four independent three-clock accesses would take twelve. On the processor side there is a request/acknowledge handshake and a read data bus with a per-word valid strobe. For write-outs there is a data-request strobe that asks for each next word one cycle before the memory write slot that uses it. A one-cycle completion pulse marks the end of each line.

Top module: `burst_line_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle: after that edge `req_ack` is 1 and `mem_en`, `mem_we`, `rd_valid`, `wr_take` and `line_done` are 0.
- R2: A request is taken at a rising edge where `req_valid` and `req_ack` are both 1. `req_ack` is 0 in the five cycles after that edge and returns to 1 in the sixth. A `req_valid` raised while `req_ack` is 0 is ignored and starts no burst.
- R3: For a fill (`req_write` = 0), count cycle 1 as the cycle after the accepting edge. `mem_en` is 1 with `mem_we` 0 in cycles 1 to 4, one word address per cycle. `rd_valid` is 1 in cycles 2 to 5 with `rd_data` carrying the word addressed one cycle earlier, so the first word takes two clocks, each later word one, and the line five.
- R4: For a write-out (`req_write` = 1), `wr_take` is 1 in cycles 1 to 4 and 0 in cycle 5. `wr_data` is sampled at the end of each cycle in which `wr_take` is 1. `mem_en` and `mem_we` are 1 in cycles 2 to 5, each carrying the next word on `mem_wdata` with its address.
- R5: With `req_wrap` = 1, word k (k = 0..3) of the burst uses the upper address bits of `req_addr` unchanged and low two bits equal to (`req_addr[1:0]` + k) mod 4.
- R6: With `req_wrap` = 0, the low two bits of `req_addr` are cleared before the burst, and word k uses low bits equal to k, so the line is walked in ascending order from its first word.
- R7: `line_done` is 1 for exactly one cycle, cycle 6, with `req_ack` 1 in the same cycle. A request presented in that cycle is accepted at its closing edge and starts a new burst with no idle gap.
- R8: `rd_valid` is never 1 during a write-out, `wr_take` is never 1 during a fill, and `mem_we` is never 1 without `mem_en`.
- R9: Pulling `rst_n` low in the middle of a burst abandons it. After the reset the block is idle, and the next request runs a complete, correct burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Requester asks for a line transfer |
| req_ack | output | 1 | Block is idle and takes the request at this edge |
| req_write | input | 1 | 1 = write-out to memory, 0 = fill from memory |
| req_wrap | input | 1 | 1 = wrap-around word order, 0 = linear order from line start |
| req_addr | input | AW | Word address of the first requested word |
| wr_data | input | DW | Write-out word, sampled while `wr_take` is high |
| wr_take | output | 1 | Asks for the next write-out word on `wr_data` |
| rd_data | output | DW | Fill word returned to the requester |
| rd_valid | output | 1 | `rd_data` holds a fill word this cycle |
| line_done | output | 1 | One-cycle pulse after the last word of a line |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe (1 = write, 0 = read) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read access |

## Verification
The completion pulse of one line and the acceptance of the next request can fall in the same cycle, because `req_ack` rises together with `line_done`. The bench provokes this by chaining a write-out directly into a fill, driving the new request in the `line_done` cycle. It then judges that the pulse is still a single cycle and that the fill's first address follows one cycle later in the new order. It also reads back the written words to confirm that no beat of either burst was lost. A second overlap, a request raised in the middle of a burst, is judged by checking that the address sequence in flight is undisturbed and that no extra burst follows.

// File: rtl/burst_pkg.sv
// burst_pkg
// Shared types for the burst line-fill controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package burst_pkg;

    // Sequencer phases of one line transfer.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // waiting for a request
        ST_LEAD   = 2'd1,  // extra first-word clock
        ST_STREAM = 2'd2   // one clock per word
    } burst_state_e;

endpackage

// File: rtl/burst_addr_gen.sv
// burst_addr_gen
// Holds the line base taken at request time and forms the word address
// for a given index inside the line, in linear or wrap-around order.
// Assumes: LINE_WORDS is a power of two, at least 4, and smaller than 2**AW.
// In linear mode the low index bits are cleared at load, so adding the
// index inside IDX_W bits never leaves the line in either mode.
module burst_addr_gen #(
    parameter int AW         = 8,
    parameter int LINE_WORDS = 4,
    parameter int IDX_W      = $clog2(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_wrap,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    word_addr
);

    logic [AW-1:0]    start_addr;
    logic [AW-1:0]    base_q;
    logic [AW-1:0]    base_src;
    logic [IDX_W-1:0] low_sum;

    // Align the start to the line when the linear order is chosen.
    always_comb begin
        if (req_wrap) begin
            start_addr = req_addr;
        end else begin
            start_addr = {req_addr[AW-1:IDX_W], {IDX_W{1'b0}}};
        end
    end

    // Capture the line base once per burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= start_addr;
        end
    end

    // Use the live request in the accepting cycle, the held base afterwards.
    always_comb begin
        base_src = load ? start_addr : base_q;
    end

    // Step the in-line index modulo the line size.
    always_comb begin
        low_sum   = base_src[IDX_W-1:0] + idx;
        word_addr = {base_src[AW-1:IDX_W], low_sum};
    end

endmodule

// File: rtl/burst_seq.sv
// burst_seq
// Phase sequencer of one line transfer: idle, one lead clock for the
// first word, then one clock per word with a beat counter.
// Assumes: start is only raised while the sequencer is idle.
module burst_seq
    import burst_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    parameter int IDX_W      = $clog2(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output burst_state_e     state,
    output logic [IDX_W-1:0] beat,
    output logic             last_beat
);

    localparam logic [IDX_W-1:0] BEAT_LAST = IDX_W'(LINE_WORDS - 1);

    // Flag the final word clock of the line.
    always_comb begin
        last_beat = (state == ST_STREAM) && (beat == BEAT_LAST);
    end

    // Advance phase and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_LEAD;
                    end
                    beat <= '0;
                end
                ST_LEAD: begin
                    state <= ST_STREAM;
                    beat  <= '0;
                end
                ST_STREAM: begin
                    if (last_beat) begin
                        state <= ST_IDLE;
                        beat  <= '0;
                    end else begin
                        beat <= beat + IDX_W'(1);
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    beat  <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_mem_port.sv
// burst_mem_port
// Output registers of the memory side. Every memory signal leaves the
// block from a flop, so the RAM sees a clean synchronous interface.
// Assumes: write data is loaded only in cycles that also issue a write.
module burst_mem_port #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr_n,
    input  logic          wload,
    input  logic [DW-1:0] wdata_n,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    // Register strobes and address every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_en   <= 1'b0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
        end else begin
            mem_en   <= en_n;
            mem_we   <= we_n && en_n;
            mem_addr <= addr_n;
        end
    end

    // Latch write data only when a write slot needs it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wdata <= '0;
        end else if (wload) begin
            mem_wdata <= wdata_n;
        end
    end

endmodule

// File: rtl/burst_line_ctrl.sv
// burst_line_ctrl
// Burst line-fill controller: takes one start address per cache line and
// moves LINE_WORDS words to or from a synchronous static RAM, two clocks
// for the first word and one for each later word.
// Assumes: the RAM returns read data one cycle after an enabled read,
// and the requester supplies wr_data in any cycle where wr_take is high.
module burst_line_ctrl
    import burst_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ack,
    input  logic          req_write,
    input  logic          req_wrap,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_take,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          line_done,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(LINE_WORDS);

    burst_state_e     state;
    logic [IDX_W-1:0] beat;
    logic             last_beat;
    logic             accept;
    logic             wr_mode_q;
    logic [IDX_W-1:0] idx_sel;
    logic [AW-1:0]    word_addr;
    logic             en_n;
    logic             we_n;
    logic             wload;
    logic             rv_n;
    logic             take_n;
    logic             done_n;
    int               beat_i;

    // Handshake: the block is ready exactly when the sequencer is idle.
    always_comb begin
        req_ack = (state == ST_IDLE);
        accept  = req_valid && req_ack;
        beat_i  = int'(beat);
    end

    // Fill data comes straight from the RAM's own output register.
    always_comb begin
        rd_data = mem_rdata;
    end

    // Remember the transfer direction for the whole line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_mode_q <= 1'b0;
        end else if (accept) begin
            wr_mode_q <= req_write;
        end
    end

    burst_seq #(
        .LINE_WORDS(LINE_WORDS),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .state    (state),
        .beat     (beat),
        .last_beat(last_beat)
    );

    burst_addr_gen #(
        .AW        (AW),
        .LINE_WORDS(LINE_WORDS),
        .IDX_W     (IDX_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .req_addr (req_addr),
        .req_wrap (req_wrap),
        .idx      (idx_sel),
        .word_addr(word_addr)
    );

    // Decide the next memory slot and requester strobes for each phase.
    always_comb begin
        idx_sel = '0;
        en_n    = 1'b0;
        we_n    = 1'b0;
        wload   = 1'b0;
        rv_n    = 1'b0;
        take_n  = 1'b0;
        done_n  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        take_n = 1'b1;
                    end else begin
                        en_n = 1'b1;
                    end
                end
            end
            ST_LEAD: begin
                if (wr_mode_q) begin
                    en_n   = 1'b1;
                    we_n   = 1'b1;
                    wload  = 1'b1;
                    take_n = 1'b1;
                end else begin
                    en_n    = 1'b1;
                    idx_sel = IDX_W'(1);
                    rv_n    = 1'b1;
                end
            end
            ST_STREAM: begin
                done_n = last_beat;
                if (wr_mode_q) begin
                    en_n    = (beat_i + 1) < LINE_WORDS;
                    we_n    = en_n;
                    wload   = en_n;
                    idx_sel = beat + IDX_W'(1);
                    take_n  = (beat_i + 2) < LINE_WORDS;
                end else begin
                    en_n    = (beat_i + 2) < LINE_WORDS;
                    idx_sel = beat + IDX_W'(2);
                    rv_n    = (beat_i + 1) < LINE_WORDS;
                end
            end
            default: begin
                done_n = 1'b0;
            end
        endcase
    end

    burst_mem_port #(
        .AW(AW),
        .DW(DW)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_n     (en_n),
        .we_n     (we_n),
        .addr_n   (word_addr),
        .wload    (wload),
        .wdata_n  (wr_data),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );

    // Register the requester-side strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            wr_take   <= 1'b0;
            line_done <= 1'b0;
        end else begin
            rd_valid  <= rv_n;
            wr_take   <= take_n;
            line_done <= done_n;
        end
    end

endmodule

// File: rtl/burst_line_ctrl_chk.sv
// burst_line_ctrl_chk
// Temporal checks on the ports of burst_line_ctrl, attached by bind.
// Assumes: default line of four words (two index bits).
module burst_line_ctrl_chk #(
    parameter int AW         = 8,
    parameter int LINE_WORDS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ack,
    input logic          req_write,
    input logic          req_wrap,
    input logic          wr_take,
    input logic          rd_valid,
    input logic          line_done,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);

    localparam int IDX_W = $clog2(LINE_WORDS);

    logic seen;

    // Mark the first clock after reset so $past never reaches before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else begin
            seen <= 1'b1;
        end
    end

    // R2: a taken request drops the acknowledge on the next cycle.
    p_ack_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_ack);

    // R3: a fill issues its first read in the cycle after acceptance.
    p_fill_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack && !req_write) |=> (mem_en && !mem_we && !rd_valid));

    // R4: a write-out first asks for data, without touching memory.
    p_write_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack && req_write) |=> (wr_take && !mem_en));

    // R5: consecutive accesses step the in-line index by one, same line.
    p_line_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && mem_en && $past(mem_en)) |->
            ((mem_addr[IDX_W-1:0] == $past(mem_addr[IDX_W-1:0]) + IDX_W'(1)) &&
             (mem_addr[AW-1:IDX_W] == $past(mem_addr[AW-1:IDX_W]))));

    // R6: a linear fill starts at the first word of the line.
    p_lin_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(req_valid && req_ack && !req_wrap && !req_write)) |->
            (mem_addr[IDX_W-1:0] == '0));

    // R7: the completion pulse lasts one cycle and coincides with ready.
    p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);
    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> req_ack);

    // R8: direction strobes are exclusive and writes need an enable.
    p_dir_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_take));
    p_we_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

endmodule

bind burst_line_ctrl burst_line_ctrl_chk #(
    .AW        (AW),
    .LINE_WORDS(LINE_WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ack  (req_ack),
    .req_write(req_write),
    .req_wrap (req_wrap),
    .wr_take  (wr_take),
    .rd_valid (rd_valid),
    .line_done(line_done),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/burst_line_ctrl_test.sv
// burst_line_ctrl_test
// Directed bench: one task per scenario, a behavioural synchronous RAM,
// and a golden image of memory kept by the bench itself.
module burst_line_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ack;
    logic          req_write;
    logic          req_wrap;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] wr_data;
    logic          wr_take;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          line_done;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    logic [DW-1:0] sram [256];
    logic [DW-1:0] gold [256];

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_line_ctrl #(.AW(AW), .DW(DW), .LINE_WORDS(4)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ack  (req_ack),
        .req_write(req_write),
        .req_wrap (req_wrap),
        .req_addr (req_addr),
        .wr_data  (wr_data),
        .wr_take  (wr_take),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .line_done(line_done),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Behavioural synchronous RAM, one cycle read latency.
    always @(posedge clk) begin
        if (mem_en && mem_we) sram[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= sram[mem_addr];
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input bit wrap, input int k);
        logic [1:0] lo;
        lo = wrap ? (a[1:0] + 2'(k)) : 2'(k);
        return {a[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] wval(input logic [AW-1:0] a, input int k);
        return 32'hC0DE_0000 + (32'(a) << 4) + 32'(k);
    endfunction

    // One full line transfer from an idle negedge; returns at the done cycle.
    task automatic burst(input bit wr, input bit wrap, input logic [AW-1:0] a,
                         input bit poke, input string rq);
        req_valid = 1'b1;
        req_write = wr;
        req_wrap  = wrap;
        req_addr  = a;
        for (int cyc = 1; cyc <= 6; cyc++) begin
            @(negedge clk);
            if (cyc == 1) req_valid = 1'b0;
            if (poke && cyc == 3) begin
                req_valid = 1'b1;
                req_addr  = a ^ 8'h40;
            end
            if (poke && cyc == 4) req_valid = 1'b0;
            if (cyc <= 5) chk("R2 ack low while busy", 32'(req_ack), 32'(0));
            if (!wr) begin
                chk("R3 read enable", 32'(mem_en), 32'(cyc <= 4));
                chk("R8 no write in fill", 32'(mem_we), 32'(0));
                chk("R8 no take in fill", 32'(wr_take), 32'(0));
                if (cyc <= 4) chk({rq, " fill address"}, 32'(mem_addr), 32'(exp_addr(a, wrap, cyc - 1)));
                chk("R3 rd_valid timing", 32'(rd_valid), 32'(cyc >= 2 && cyc <= 5));
                if (cyc >= 2 && cyc <= 5)
                    chk("R3 fill data", rd_data, gold[exp_addr(a, wrap, cyc - 2)]);
            end else begin
                chk("R4 wr_take timing", 32'(wr_take), 32'(cyc <= 4));
                if (cyc <= 4) wr_data = wval(a, cyc - 1);
                chk("R4 write strobe", 32'(mem_we), 32'(cyc >= 2 && cyc <= 5));
                chk("R8 no valid in write-out", 32'(rd_valid), 32'(0));
                if (cyc >= 2 && cyc <= 5) begin
                    chk({rq, " write address"}, 32'(mem_addr), 32'(exp_addr(a, wrap, cyc - 2)));
                    chk("R4 write data", mem_wdata, wval(a, cyc - 2));
                    chk("R4 write enable", 32'(mem_en), 32'(1));
                    gold[exp_addr(a, wrap, cyc - 2)] = wval(a, cyc - 2);
                end
            end
            if (cyc == 6) begin
                chk("R7 done pulse", 32'(line_done), 32'(1));
                chk("R7 ready with done", 32'(req_ack), 32'(1));
                chk("R7 idle memory at done", 32'(mem_en), 32'(0));
            end else begin
                chk("R7 no early done", 32'(line_done), 32'(0));
            end
        end
    endtask

    task automatic idle_after(input string rq);
        @(negedge clk);
        chk({rq, " done cleared"}, 32'(line_done), 32'(0));
        chk({rq, " no new access"}, 32'(mem_en), 32'(0));
        chk({rq, " ready"}, 32'(req_ack), 32'(1));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ack", 32'(req_ack), 32'(1));
        chk("R1 mem_en", 32'(mem_en), 32'(0));
        chk("R1 mem_we", 32'(mem_we), 32'(0));
        chk("R1 rd_valid", 32'(rd_valid), 32'(0));
        chk("R1 wr_take", 32'(wr_take), 32'(0));
        chk("R1 line_done", 32'(line_done), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_fill_wrap;
        burst(1'b0, 1'b1, 8'h36, 1'b0, "R5");
        idle_after("R7");
    endtask

    task automatic t_fill_linear;
        burst(1'b0, 1'b0, 8'h4B, 1'b0, "R6");
        idle_after("R7");
    endtask

    task automatic t_write_wrap;
        burst(1'b1, 1'b1, 8'h13, 1'b0, "R5");
        idle_after("R7");
        burst(1'b0, 1'b0, 8'h11, 1'b0, "R4 readback");
        idle_after("R7");
    endtask

    task automatic t_write_linear;
        burst(1'b1, 1'b0, 8'hE6, 1'b0, "R6");
        idle_after("R7");
        burst(1'b0, 1'b1, 8'hE5, 1'b0, "R4 readback");
        idle_after("R7");
    endtask

    task automatic t_busy_ignore;
        burst(1'b0, 1'b1, 8'h21, 1'b1, "R2 poked");
        idle_after("R2 ignored request");
    endtask

    task automatic t_back_to_back;
        burst(1'b1, 1'b1, 8'h7F, 1'b0, "R7 chained write");
        burst(1'b0, 1'b1, 8'h7E, 1'b0, "R7 chained fill");
        idle_after("R7");
    endtask

    task automatic t_reset_abort;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_wrap  = 1'b1;
        req_addr  = 8'h92;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 ack after abort", 32'(req_ack), 32'(1));
        chk("R9 mem_en after abort", 32'(mem_en), 32'(0));
        chk("R9 rd_valid after abort", 32'(rd_valid), 32'(0));
        chk("R9 done after abort", 32'(line_done), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 stays idle", 32'(mem_en), 32'(0));
        burst(1'b0, 1'b1, 8'hA7, 1'b0, "R9 recovery");
        idle_after("R9");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            sram[i] = 32'h5A00_0000 + 32'(i) * 32'h0001_0003;
            gold[i] = 32'h5A00_0000 + 32'(i) * 32'h0001_0003;
        end
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wrap  = 1'b0;
        req_addr  = '0;
        wr_data   = '0;
        @(negedge clk);
        t_reset();
        t_fill_wrap();
        t_fill_linear();
        t_write_wrap();
        t_write_linear();
        t_busy_ignore();
        t_back_to_back();
        t_reset_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule